// File: doc/BRIEF.md
# Vertical Measurement-Line Timing Sequencer

This block turns the digitised comparator outputs of a multi-level sandcastle pulse, plus an optional vertical flyback input, into the timing gates used by automatic cathode cut-off control. It recovers the line pulse and the burst key from the sandcastle. It tells the vertical component apart from ordinary line blanking. After vertical blanking it marks out four whole lines: one for leakage measurement, then one each for the red, green and blue cut-off measurements.

The measurement lines start on the first complete line after the earlier of two vertical references has ended: the sandcastle vertical component or the flyback pulse. Output blanking runs from the start of the sandcastle vertical component until the later of two events: the end of the last measurement line, or the end of that vertical component. A brightness-disable flag covers the vertical interval and the measurement lines. A measurement-enable flag is cleared when the flyback input stays low for a whole field. While it is clear, no sequence starts and no clamp gate is produced.

All inputs are expected to be synchronous to `clk`. One sandcastle decode mode handles a three-level pulse and the other handles a two-level pulse.

Top module: `vmeas_timing`

## Requirements
- R1: With `two_level`=0, line counting uses rising edges of `sc_mid`. `clamp_gate` follows `sc_hi` (gated by `meas_en`) one cycle later, so a line pulse that only raises `sc_mid` gives no clamp.
- R2: With `two_level`=1, both line counting and `clamp_gate` come from `sc_mid`, and `sc_hi` has no effect on any output.
- R3: A blanking interval (`sc_lo` high) is treated as vertical once two line edges have occurred inside it. An interval that holds only one edge is ordinary line blanking.
- R4: The windows follow the order leakage, red, green, blue (`leak_win`, `red_win`, `grn_win`, `blu_win`). Each window lasts exactly from one line edge to the next.
- R5: The leakage window starts at the first line edge after the earlier vertical reference has ended. That reference is either the fall of `sc_lo` closing the vertical component or a fall of `vfb_in`. A line already under way when the reference ends is skipped.
- R6: Only one sequence runs per field, so the vertical reference that ends later is ignored.
- R7: `blank_gate` is high, one cycle late, while `sc_lo` is high or a sequence is pending or running. Blanking therefore extends to the later of the sequence end and the end of the vertical component.
- R8: `bright_dis` is high while a vertical component is detected and while a sequence is pending or running.
- R9: `meas_en` is low once `vfb_in` has stayed low over a whole field, measured between vertical detections. While it is low, no windows open and `clamp_gate` stays low.
- R10: At most one of the four windows is high in any cycle.
- R11: Synchronous active-low reset clears every output, including a sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sc_lo | input | 1 | Sandcastle above blanking threshold |
| sc_mid | input | 1 | Sandcastle above middle threshold |
| sc_hi | input | 1 | Sandcastle above top threshold (three-level only) |
| vfb_in | input | 1 | Vertical flyback level; high when open |
| two_level | input | 1 | 1 selects two-level sandcastle decoding |
| leak_win | output | 1 | Leakage measurement line |
| red_win | output | 1 | Red cut-off measurement line |
| grn_win | output | 1 | Green cut-off measurement line |
| blu_win | output | 1 | Blue cut-off measurement line |
| blank_gate | output | 1 | Extended output blanking |
| clamp_gate | output | 1 | Burst-key clamp gate |
| bright_dis | output | 1 | Brightness-adjust disable |
| meas_en | output | 1 | Flyback activity seen; measurement allowed |

## Verification
A wrong count in the vertical detector shows up at `bright_dis` in the second line of a vertical interval. It also shifts every window by whole lines, so the first mis-timed window appears within five lines of the vertical end. A sequencer stuck in a non-idle state holds `blank_gate` high through active video from the next line onward. A stale field flag shows up in the following field as windows and clamps that should be absent. Each scenario therefore runs two fields and checks only the second.

// File: rtl/vmt_pkg.sv
// Package: shared state encoding and window count for the measurement-line sequencer.
package vmt_pkg;
    // Sequencer states; the four window states are consecutive codes.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_LEAK = 3'd2,
        ST_RED  = 3'd3,
        ST_GRN  = 3'd4,
        ST_BLU  = 3'd5
    } seq_state_t;

    localparam int NUM_WIN   = 4;
    localparam int WIN_BASE  = 2;
endpackage

// File: rtl/vmt_sc_decode.sv
// Sandcastle decoder.
// Recovers line edges and burst key from comparator levels, and detects the
// vertical component as a blanking interval holding VERT_EDGES line edges.
// Assumes comparator outputs are already synchronous to clk.
module vmt_sc_decode #(
    parameter int VERT_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sc_lo,
    input  logic sc_mid,
    input  logic sc_hi,
    input  logic two_level,
    output logic line_rise,
    output logic burst,
    output logic vert_act,
    output logic vert_start,
    output logic vert_end
);
    localparam int CNT_W = $clog2(VERT_EDGES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(VERT_EDGES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(VERT_EDGES - 1);

    logic             mid_q;
    logic [CNT_W-1:0] edge_cnt;
    logic             vert_q;

    assign line_rise  = sc_mid & ~mid_q;
    assign burst      = two_level ? sc_mid : sc_hi;
    assign vert_start = sc_lo & line_rise & ~vert_q & (edge_cnt == CNT_LAST);
    assign vert_end   = vert_q & ~sc_lo;
    assign vert_act   = vert_q;

    // Delay middle comparator for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) mid_q <= 1'b0;
        else        mid_q <= sc_mid;
    end

    // Count line edges inside the current blanking interval, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !sc_lo)                     edge_cnt <= '0;
        else if (line_rise && edge_cnt != CNT_MAX) edge_cnt <= edge_cnt + 1'b1;
    end

    // Vertical component flag: set on the deciding edge, cleared when blanking ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !sc_lo) vert_q <= 1'b0;
        else if (vert_start)  vert_q <= 1'b1;
    end
endmodule

// File: rtl/vmt_vfb_mon.sv
// Flyback monitor.
// Detects the flyback trailing edge and tracks whether the flyback input was
// high during the current or the previous field; field boundary is vertical detection.
// Assumes an unconnected flyback input reads high.
module vmt_vfb_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic vfb_in,
    input  logic vert_start,
    output logic vfb_fall,
    output logic meas_en
);
    logic vfb_q;
    logic seen_hi;
    logic hold;

    assign vfb_fall = vfb_q & ~vfb_in;
    assign meas_en  = hold | seen_hi;

    // Delay flyback level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) vfb_q <= 1'b0;
        else        vfb_q <= vfb_in;
    end

    // Record flyback activity in the running field; restart at each vertical.
    always_ff @(posedge clk) begin
        if (!rst_n)          seen_hi <= 1'b0;
        else if (vert_start) seen_hi <= vfb_in;
        else if (vfb_in)     seen_hi <= 1'b1;
    end

    // Keep the previous field's activity for one more field.
    always_ff @(posedge clk) begin
        if (!rst_n)          hold <= 1'b0;
        else if (vert_start) hold <= seen_hi;
    end
endmodule

// File: rtl/vmt_seq.sv
// Measurement-line sequencer.
// Arms on the first vertical reference end of a field, waits for the next
// complete line, then steps leakage/red/green/blue one line each.
// Assumes line_rise is a single-cycle pulse per line.
module vmt_seq
    import vmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_rise,
    input  logic               ref_end,
    input  logic               meas_en,
    input  logic               vert_start,
    output logic               busy,
    output logic [NUM_WIN-1:0] win
);
    seq_state_t state, state_nx;
    logic       fired;
    logic [2:0] st_bits;

    assign st_bits = state;
    assign busy    = (state != ST_IDLE);

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (ref_end && meas_en && !fired) state_nx = ST_WAIT;
            ST_WAIT: if (line_rise) state_nx = ST_LEAK;
            ST_LEAK: if (line_rise) state_nx = ST_RED;
            ST_RED:  if (line_rise) state_nx = ST_GRN;
            ST_GRN:  if (line_rise) state_nx = ST_BLU;
            ST_BLU:  if (line_rise) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // One sequence per field: block re-arming until the next vertical.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     fired <= 1'b0;
        else if (vert_start)                            fired <= 1'b0;
        else if (state == ST_IDLE && state_nx == ST_WAIT) fired <= 1'b1;
    end

    // One window decode per measurement line.
    for (genvar k = 0; k < NUM_WIN; k++) begin : gen_win
        assign win[k] = (st_bits == 3'(WIN_BASE + k));
    end
endmodule

// File: rtl/vmeas_timing.sv
// Top: vertical measurement-line timing sequencer.
// Joins sandcastle decode, flyback monitor and sequencer; registers the
// blanking and clamp gates. Assumes all inputs synchronous to clk.
module vmeas_timing #(
    parameter int VERT_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sc_lo,
    input  logic sc_mid,
    input  logic sc_hi,
    input  logic vfb_in,
    input  logic two_level,
    output logic leak_win,
    output logic red_win,
    output logic grn_win,
    output logic blu_win,
    output logic blank_gate,
    output logic clamp_gate,
    output logic bright_dis,
    output logic meas_en
);
    import vmt_pkg::*;

    logic               line_rise, burst, vert_act, vert_start, vert_end;
    logic               vfb_fall, busy;
    logic [NUM_WIN-1:0] win;

    vmt_sc_decode #(.VERT_EDGES(VERT_EDGES)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .sc_lo      (sc_lo),
        .sc_mid     (sc_mid),
        .sc_hi      (sc_hi),
        .two_level  (two_level),
        .line_rise  (line_rise),
        .burst      (burst),
        .vert_act   (vert_act),
        .vert_start (vert_start),
        .vert_end   (vert_end)
    );

    vmt_vfb_mon u_vfb (
        .clk        (clk),
        .rst_n      (rst_n),
        .vfb_in     (vfb_in),
        .vert_start (vert_start),
        .vfb_fall   (vfb_fall),
        .meas_en    (meas_en)
    );

    vmt_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_rise  (line_rise),
        .ref_end    (vert_end | vfb_fall),
        .meas_en    (meas_en),
        .vert_start (vert_start),
        .busy       (busy),
        .win        (win)
    );

    assign leak_win   = win[0];
    assign red_win    = win[1];
    assign grn_win    = win[2];
    assign blu_win    = win[3];
    assign bright_dis = vert_act | busy;

    // Register the extended blanking and the enabled clamp gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank_gate <= 1'b0;
            clamp_gate <= 1'b0;
        end else begin
            blank_gate <= sc_lo | busy;
            clamp_gate <= burst & meas_en;
        end
    end
endmodule

// File: rtl/vmt_chk.sv
// Checker: temporal properties of the sequencer outputs, bound to the top.
module vmt_chk (
    input logic clk,
    input logic rst_n,
    input logic leak_win,
    input logic red_win,
    input logic grn_win,
    input logic blu_win,
    input logic blank_gate,
    input logic clamp_gate,
    input logic bright_dis,
    input logic meas_en
);
    AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({leak_win, red_win, grn_win, blu_win})); // R10

    AST_LEAK_THEN_RED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(leak_win) |-> red_win); // R4

    AST_BLUE_AFTER_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blu_win) |-> $past(grn_win)); // R4

    AST_WIN_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        (leak_win || red_win || grn_win || blu_win) |-> blank_gate); // R7

    AST_WIN_NO_BRIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (leak_win || red_win || grn_win || blu_win) |-> bright_dis); // R8

    AST_NO_CLAMP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!meas_en && !$past(meas_en)) |-> !clamp_gate); // R9
endmodule

bind vmeas_timing vmt_chk u_chk (.*);

// File: tb/vmeas_timing_tb.sv
module vmeas_timing_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sc_lo = 1'b0, sc_mid = 1'b0, sc_hi = 1'b0, vfb_in = 1'b0, two_level = 1'b0;
    logic leak_win, red_win, grn_win, blu_win, blank_gate, clamp_gate, bright_dis, meas_en;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    localparam int LINES = 14;
    localparam int NSC   = 10;
    // Scenario: {two_level[10], vfb kind[9:8] (0 high,1 pulse,2 low), V[7:4], F[3:0]}
    localparam logic [10:0] SCEN [NSC] = '{
        {1'b0, 2'd0, 4'd3, 4'd0},
        {1'b0, 2'd1, 4'd4, 4'd2},
        {1'b0, 2'd1, 4'd3, 4'd5},
        {1'b1, 2'd0, 4'd3, 4'd0},
        {1'b1, 2'd1, 4'd5, 4'd2},
        {1'b0, 2'd2, 4'd3, 4'd0},
        {1'b1, 2'd2, 4'd4, 4'd0},
        {1'b0, 2'd1, 4'd3, 4'd3},
        {1'b0, 2'd1, 4'd4, 4'd3},
        {1'b1, 2'd1, 4'd3, 4'd4}
    };

    int cur_v, cur_f, cur_kind, cur_first;
    logic cur_mode2;

    always #10 clk = ~clk;

    vmeas_timing u_dut (
        .clk(clk), .rst_n(rst_n), .sc_lo(sc_lo), .sc_mid(sc_mid), .sc_hi(sc_hi),
        .vfb_in(vfb_in), .two_level(two_level), .leak_win(leak_win), .red_win(red_win),
        .grn_win(grn_win), .blu_win(blu_win), .blank_gate(blank_gate),
        .clamp_gate(clamp_gate), .bright_dis(bright_dis), .meas_en(meas_en)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit busy_exp(input int i);
        return (cur_kind != 2) && (i >= cur_first - 1) && (i <= cur_first + 3);
    endfunction

    // One line of 16 cycles: sample just after each negedge, then drive.
    task automatic run_line(input int li, input bit chk);
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            if (chk) begin
                if (c == 11) begin
                    logic [3:0] w;
                    w[0] = (li == cur_first);
                    w[1] = (li == cur_first + 1);
                    w[2] = (li == cur_first + 2);
                    w[3] = (li == cur_first + 3);
                    if (cur_kind == 2) w = 4'b0;
                    check({4'b0, blu_win, grn_win, red_win, leak_win}, {4'b0, w[3], w[2], w[1], w[0]},
                          (cur_kind == 1 && cur_f >= cur_v) ? "R4 R5 R6 R10 windows" : "R4 R5 R10 windows");
                    check({7'b0, blank_gate}, {7'b0, (li < cur_v) || busy_exp(li)}, "R7 blank");
                    check({7'b0, bright_dis}, {7'b0, (li >= 1 && li < cur_v) || busy_exp(li)}, "R3 R8 bright");
                    if (li >= 2) check({7'b0, meas_en}, {7'b0, cur_kind != 2}, "R9 meas_en");
                end
                if (c == 3 && li >= 2 && !cur_mode2)
                    check({7'b0, clamp_gate}, 8'd0, "R1 line pulse gives no clamp");
                if (c == 5 && li >= 2)
                    check({7'b0, clamp_gate}, {7'b0, cur_kind != 2}, cur_mode2 ? "R2 R9 clamp" : "R1 R9 clamp");
                if (c == 14 && li >= 2)
                    check({7'b0, clamp_gate}, 8'd0, "R2 top comparator ignored");
            end
            sc_lo  = (li < cur_v) || (c < 6);
            if (cur_mode2) begin
                sc_mid = (c == 3 || c == 4);
                sc_hi  = (c == 12 || c == 13);
            end else begin
                sc_mid = (c >= 1 && c <= 4);
                sc_hi  = (c == 3 || c == 4);
            end
            case (cur_kind)
                0:       vfb_in = 1'b1;
                1:       vfb_in = (li < cur_f) || (li == cur_f && c < 8);
                default: vfb_in = 1'b0;
            endcase
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check({leak_win, red_win, grn_win, blu_win, blank_gate, clamp_gate, bright_dis, meas_en},
              8'h00, "R11 reset state");
        rst_n = 1'b1;

        // Scenario table: two fields each, second one checked.
        for (int s = 0; s < NSC; s++) begin
            cur_mode2 = SCEN[s][10];
            cur_kind  = int'(SCEN[s][9:8]);
            cur_v     = int'(SCEN[s][7:4]);
            cur_f     = int'(SCEN[s][3:0]);
            two_level = cur_mode2;
            cur_first = (cur_kind == 2) ? -100 :
                        (cur_kind == 1 && cur_f < cur_v) ? cur_f + 1 : cur_v + 1;
            for (int fld = 0; fld < 2; fld++)
                for (int li = 0; li < LINES; li++)
                    run_line(li, fld == 1);
        end

        // Directed: reset during the leakage line clears everything (R11).
        cur_mode2 = 1'b0; two_level = 1'b0; cur_kind = 0; cur_v = 3; cur_f = 0; cur_first = 4;
        for (int li = 0; li < LINES; li++) run_line(li, 1'b0);
        for (int li = 0; li <= 4; li++) run_line(li, 1'b0);
        @(negedge clk);
        check({7'b0, leak_win}, 8'd1, "R5 leakage open before reset");
        rst_n = 1'b0;
        sc_lo = 1'b0; sc_mid = 1'b0; sc_hi = 1'b0;
        repeat (2) @(negedge clk);
        check({leak_win, red_win, grn_win, blu_win, blank_gate, clamp_gate, bright_dis, meas_en},
              8'h00, "R11 reset mid-sequence");
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        check({leak_win, red_win, grn_win, blu_win, 4'b0}, 8'h00, "R11 stays idle after reset");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule